// File: doc/BRIEF.md
# Gated GPIO Output Change Notifier

This block keeps the output side of a general-purpose I/O port: a 24-bit output data register and a 24-bit output-enable register. Both are loaded one byte at a time over a simple byte-wide register bus. Each line is driven to its data bit gated by its enable bit. Whenever a register write changes any driven line, the block raises a one-cycle change pulse for that line, so that downstream logic can follow only the edges.

Only the lower 16 lines reach pins. The upper byte lane of each register is plain storage that reads back what was written and never causes a pulse. Clearing an enable bit pulls its line low and produces a pulse, even when the data bit stays the same. Reads are combinational: the byte at the presented address appears on the read port in the same cycle.

Top module: `gpio_chg_notify`

## Requirements
- R1: After reset the data and enable registers read 0, `pin_level` is 0 and `chg_pulse` is 0.
- R2: A write to offset 0x78+n (n = 0..2) loads data bits 8n+7..8n and leaves the other data bits unchanged. A read of that offset returns the stored byte.
- R3: A write to offset 0x7C+n (n = 0..2) loads enable bits 8n+7..8n and leaves the other enable bits unchanged. A read of that offset returns the stored byte.
- R4: From the cycle after a register write, `pin_level[i]` equals data bit i AND enable bit i for i = 0..15. Without a write it holds its value.
- R5: In the cycle after a register write, `chg_pulse[i]` is 1 exactly for the lines whose driven level differs from its value before the write. In the next cycle without a write the pulse is 0 again.
- R6: Clearing an enable bit whose data bit is 1 drives that line to 0 and pulses it.
- R7: A write that leaves every driven level unchanged (for example a data write under a zero enable) produces no pulse.
- R8: Writes to lane 2 (bits 23..16) are stored and read back, but they never change `pin_level` and never pulse.
- R9: A write to any other offset changes no register, level or pulse. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the byte at `bus_addr` |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for `bus_addr`, combinational |
| pin_level | output | 16 | Driven level of each external line |
| chg_pulse | output | 16 | One-cycle per-line change indication, valid with `pin_level` |

## Verification
A corrupted data or enable byte shows on the read port as soon as that offset is addressed. If the byte is in the lower two lanes, it also shows on `pin_level` one cycle after the next write. A stale previous-level register shows as a missing or extra `chg_pulse` bit in the cycle after the write that follows, because every pulse is compared against the XOR of the levels before and after that write. The sweeps load every byte value into every lane of both registers, and they touch every offset outside the map, so a wrong lane, a wrong bit or a leaked upper-lane bit shows within one write.

// File: rtl/gon_pkg.sv
package gon_pkg;

    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_DATA = 2'd1,
        REG_OE   = 2'd2
    } reg_kind_e;

endpackage

// File: rtl/gon_decode.sv
module gon_decode
    import gon_pkg::*;
#(
    parameter int LANES = 3,
    parameter int AW = 8,
    parameter logic [AW-1:0] DATA_BASE = 8'h78,
    parameter logic [AW-1:0] OE_BASE = 8'h7C
) (
    input  logic [AW-1:0]    addr,
    output reg_kind_e        kind,
    output logic [LANES-1:0] lane_sel
);
    logic [LANES-1:0] data_hit;
    logic [LANES-1:0] oe_hit;

    for (genvar i = 0; i < LANES; i++) begin : g_hit
        assign data_hit[i] = (addr == DATA_BASE + AW'(i));
        assign oe_hit[i]   = (addr == OE_BASE + AW'(i));
    end

    always_comb begin
        if (|data_hit) begin
            kind = REG_DATA;
        end else if (|oe_hit) begin
            kind = REG_OE;
        end else begin
            kind = REG_NONE;
        end
        lane_sel = data_hit | oe_hit;
    end
endmodule

// File: rtl/gon_lane_merge.sv
module gon_lane_merge #(
    parameter int LANES = 3,
    localparam int REG_W = LANES * 8
) (
    input  logic [REG_W-1:0] cur,
    input  logic [7:0]       wbyte,
    input  logic [LANES-1:0] sel,
    input  logic             en,
    output logic [REG_W-1:0] nxt,
    output logic [7:0]       rbyte
);
    logic [LANES-1:0][7:0] masked;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign nxt[8*i +: 8] = (en && sel[i]) ? wbyte : cur[8*i +: 8];
        assign masked[i]     = sel[i] ? cur[8*i +: 8] : 8'h00;
    end

    always_comb begin
        rbyte = 8'h00;
        for (int i = 0; i < LANES; i++) begin
            rbyte = rbyte | masked[i];
        end
    end
endmodule

// File: rtl/gon_change_detect.sv
module gon_change_detect #(
    parameter int LINES = 16
) (
    input  logic             fire,
    input  logic [LINES-1:0] old_lvl,
    input  logic [LINES-1:0] new_lvl,
    output logic [LINES-1:0] pulse
);
    always_comb begin
        pulse = fire ? (old_lvl ^ new_lvl) : '0;
    end
endmodule

// File: rtl/gpio_chg_notify.sv
module gpio_chg_notify
    import gon_pkg::*;
#(
    parameter int LANES = 3,
    parameter int LINES = 16,
    parameter int AW = 8,
    parameter logic [AW-1:0] DATA_BASE = 8'h78,
    parameter logic [AW-1:0] OE_BASE = 8'h7C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [AW-1:0]    bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic [LINES-1:0] pin_level,
    output logic [LINES-1:0] chg_pulse
);
    localparam int REG_W = LANES * 8;

    typedef struct packed {
        logic [REG_W-1:0] dat;
        logic [REG_W-1:0] oe;
        logic [LINES-1:0] lvl;
        logic [LINES-1:0] pulse;
    } state_t;

    state_t st_d, st_q;

    reg_kind_e        kind;
    logic [LANES-1:0] lane_sel;
    logic [REG_W-1:0] dat_nxt, oe_nxt, eff_nxt;
    logic [7:0]       dat_rd, oe_rd;
    logic [LINES-1:0] pulse_calc;
    logic             hit_wr;

    gon_decode #(
        .LANES(LANES), .AW(AW), .DATA_BASE(DATA_BASE), .OE_BASE(OE_BASE)
    ) decode_i (
        .addr(bus_addr), .kind(kind), .lane_sel(lane_sel)
    );

    gon_lane_merge #(.LANES(LANES)) dat_merge_i (
        .cur(st_q.dat), .wbyte(bus_wdata), .sel(lane_sel),
        .en(bus_wr && (kind == REG_DATA)), .nxt(dat_nxt), .rbyte(dat_rd)
    );

    gon_lane_merge #(.LANES(LANES)) oe_merge_i (
        .cur(st_q.oe), .wbyte(bus_wdata), .sel(lane_sel),
        .en(bus_wr && (kind == REG_OE)), .nxt(oe_nxt), .rbyte(oe_rd)
    );

    assign hit_wr  = bus_wr && (kind != REG_NONE);
    assign eff_nxt = dat_nxt & oe_nxt;

    gon_change_detect #(.LINES(LINES)) detect_i (
        .fire(hit_wr), .old_lvl(st_q.lvl), .new_lvl(eff_nxt[LINES-1:0]),
        .pulse(pulse_calc)
    );

    always_comb begin
        st_d       = st_q;
        st_d.dat   = dat_nxt;
        st_d.oe    = oe_nxt;
        st_d.pulse = pulse_calc;
        if (hit_wr) begin
            st_d.lvl = eff_nxt[LINES-1:0];
        end
        unique case (kind)
            REG_DATA: bus_rdata = dat_rd;
            REG_OE:   bus_rdata = oe_rd;
            default:  bus_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_level = st_q.lvl;
    assign chg_pulse = st_q.pulse;
endmodule

// File: rtl/gon_checker.sv
module gon_checker #(
    parameter int LANES = 3,
    parameter int LINES = 16,
    parameter int AW = 8,
    parameter logic [AW-1:0] DATA_BASE = 8'h78,
    parameter logic [AW-1:0] OE_BASE = 8'h7C
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [AW-1:0]    bus_addr,
    input logic [7:0]       bus_rdata,
    input logic [LINES-1:0] pin_level,
    input logic [LINES-1:0] chg_pulse
);
    logic mapped;
    always_comb begin
        mapped = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (bus_addr == DATA_BASE + AW'(i) || bus_addr == OE_BASE + AW'(i)) begin
                mapped = 1'b1;
            end
        end
    end

    AST_PULSE_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (chg_pulse == ($past(pin_level) ^ pin_level))); // R5
    AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (chg_pulse == '0)); // R5
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pin_level)); // R4
    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> ($stable(pin_level) && chg_pulse == '0)); // R9
    AST_FOREIGN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == 8'h00)); // R9
endmodule

bind gpio_chg_notify gon_checker #(
    .LANES(LANES), .LINES(LINES), .AW(AW), .DATA_BASE(DATA_BASE), .OE_BASE(OE_BASE)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .pin_level(pin_level), .chg_pulse(chg_pulse)
);

// File: tb/gpio_chg_notify_tb_top.sv
module gpio_chg_notify_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [15:0] pin_level;
    logic [15:0] chg_pulse;

    int checks = 0;
    int errors = 0;

    logic [23:0] dat_m = '0;
    logic [23:0] oe_m = '0;
    logic [15:0] prev_m = '0;

    always #5 clk = ~clk;

    gpio_chg_notify dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_level(pin_level), .chg_pulse(chg_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, let posedge latch, check at following negedge
    task automatic wr(input logic [7:0] a, input logic [7:0] v, input string req);
        logic [15:0] lvl;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        if (a >= 8'h78 && a <= 8'h7A) dat_m[8*(a-8'h78) +: 8] = v;
        if (a >= 8'h7C && a <= 8'h7E) oe_m[8*(a-8'h7C) +: 8] = v;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        lvl = dat_m[15:0] & oe_m[15:0];
        chk({req, " level"}, 32'(pin_level), 32'(lvl));
        chk({req, " pulse"}, 32'(chg_pulse), 32'(lvl ^ prev_m));
        prev_m = lvl;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(req, 32'(bus_rdata), 32'(exp));
    endtask

    task automatic idle(input string req);
        @(posedge clk);
        @(negedge clk);
        chk({req, " idle pulse"}, 32'(chg_pulse), 32'h0);
        chk({req, " idle level"}, 32'(pin_level), 32'(prev_m));
    endtask

    initial begin
        #1_500_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 level", 32'(pin_level), 32'h0);
        chk("R1 pulse", 32'(chg_pulse), 32'h0);
        for (int n = 0; n < 3; n++) begin
            rd(8'(8'h78 + n), 8'h00, "R1 data read");
            rd(8'(8'h7C + n), 8'h00, "R1 oe read");
        end
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(pin_level), 32'h0);

        // R6 enable clear with data high
        wr(8'h78, 8'hFF, "R6 data");
        wr(8'h7C, 8'hFF, "R6 oe set");
        chk("R6 level high", 32'(pin_level[7:0]), 32'hFF);
        wr(8'h7C, 8'h00, "R6 oe clear");
        chk("R6 pulse", 32'(chg_pulse[7:0]), 32'hFF);
        chk("R6 low", 32'(pin_level[7:0]), 32'h00);
        idle("R5");

        // R7 data write under zero enable
        wr(8'h79, 8'hA5, "R7 data no oe");
        chk("R7 no pulse", 32'(chg_pulse), 32'h0);

        // R8 upper lane is storage only
        wr(8'h7E, 8'hFF, "R8 oe lane2");
        wr(8'h7A, 8'h3C, "R8 data lane2");
        chk("R8 no pulse", 32'(chg_pulse), 32'h0);
        rd(8'h7A, 8'h3C, "R8 data read");
        rd(8'h7E, 8'hFF, "R8 oe read");

        // R2 R3 R4 R5 sweep of every byte value in every lane
        for (int lane = 0; lane < 3; lane++) begin
            for (int v = 0; v < 256; v++) begin
                wr(8'(8'h78 + lane), 8'(v), "R2 R4 R5 data sweep");
                wr(8'(8'h7C + lane), 8'(v ^ 8'h5A), "R3 R4 R5 oe sweep");
                if (v % 17 == 0) begin
                    rd(8'(8'h78 + lane), 8'(v), "R2 readback");
                    rd(8'(8'h7C + lane), 8'(v ^ 8'h5A), "R3 readback");
                    idle("R5");
                end
            end
            for (int n = 0; n < 3; n++) begin
                rd(8'(8'h78 + n), dat_m[8*n +: 8], "R2 lane isolation");
                rd(8'(8'h7C + n), oe_m[8*n +: 8], "R3 lane isolation");
            end
        end

        // R9 every unmapped offset
        for (int a = 0; a < 256; a++) begin
            if (!((a >= 8'h78 && a <= 8'h7A) || (a >= 8'h7C && a <= 8'h7E))) begin
                wr(8'(a), 8'hFF, "R9 foreign write");
                rd(8'(a), 8'h00, "R9 foreign read");
            end
        end
        for (int n = 0; n < 3; n++) begin
            rd(8'(8'h78 + n), dat_m[8*n +: 8], "R9 data kept");
            rd(8'(8'h7C + n), oe_m[8*n +: 8], "R9 oe kept");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule